// File: doc/BRIEF.md
# Trigger Source Selector with Coincidence and Second-Level Downscale

The block merges up to thirteen raw trigger lines into a single first-level trigger pulse and a 4-bit type code, and derives a second-level trigger pulse from one of several origins. The raw lines are five LVDS inputs, five LVTTL inputs, a fast reference line, an internal self-trigger line, and a software trigger held in the control word. Every raw line first crosses a two-stage synchroniser, so asynchronous inputs are allowed. An enabled source produces a trigger on its rising edge only. Three fixed line pairs can also be enabled as coincidences, which fire when both lines of the pair become high together.

A 32-bit control word sets the per-source enables, the coincidence enables, the software trigger bit, the second-level origin and the downscale count. A separate 5-bit type-select word can force the type code. Every port is a plain control or status pin. The outputs are single-cycle pulses with no valid/ready handshake and no back-pressure. Downstream logic must take each pulse in the cycle it appears.

Top module: `trig_src_sel`

## Requirements
- R1: While `rst_n` is low, `l1_trig_o`, `l1_type_o` and `l2_trig_o` are all zero.
- R2: Control bits 4:0 enable LVDS lines 4:0 (bit i enables line i), and control bits 9:5 enable LVTTL lines 4:0 (bit 5+i enables line i). A 0-to-1 change of an enabled line, driven before a clock edge, raises `l1_trig_o` for exactly one cycle after the third edge. A disabled line or a falling edge does not raise it.
- R3: Control bit 10 enables the fast reference line and control bit 11 enables the self-trigger line, with the edge rule and latency of R2.
- R4: Control bit 13 enables the software trigger, which is control bit 28. It fires once on a 0-to-1 change of that bit, with the latency of R2. Holding the bit high does not fire it again.
- R5: Control bit 12 enables the coincidence of LVDS lines 0 and 1. Bit 14 enables the coincidence of LVTTL lines 0 and 1, and bit 15 enables the coincidence of LVTTL lines 2 and 3. A coincidence fires when the AND of its pair changes from 0 to 1.
- R6: When `type_sel_i[4]` is 0, `l1_type_o` carries, during the pulse, the enable-bit number (0 to 15) of the lowest-numbered enabled source that fired in that cycle.
- R7: When `type_sel_i[4]` is 1, `l1_type_o` equals `type_sel_i[3:0]` during the pulse. Outside a pulse, `l1_type_o` is 0.
- R8: With control bits 17:16 = 00 (automatic), `l2_trig_o` pulses together with every N-th `l1_trig_o`, where N is control bits 27:20 and a value of 0 acts as 1. The count restarts after each second-level pulse and whenever another mode is selected.
- R9: Control bits 17:16 = 01 make `l2_trig_o` follow rising edges of `l2_lvds_i`, and 10 make it follow rising edges of `l2_local_i`, both with the latency of R2. The value 11 keeps `l2_trig_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lvds_trig_i | input | 5 | LVDS trigger lines, asynchronous |
| ttl_trig_i | input | 5 | LVTTL trigger lines, asynchronous |
| ref_trig_i | input | 1 | Fast reference trigger line |
| self_trig_i | input | 1 | Internal self-trigger line |
| ctrl_i | input | 32 | Control word: enables, software bit, second-level mode, downscale |
| type_sel_i | input | 5 | Bit 4 forces the type; bits 3:0 give the forced type |
| l2_lvds_i | input | 1 | Second-level trigger line from LVDS |
| l2_local_i | input | 1 | Local second-level trigger line |
| l1_trig_o | output | 1 | First-level trigger pulse |
| l1_type_o | output | 4 | First-level trigger type, valid with the pulse |
| l2_trig_o | output | 1 | Second-level trigger pulse |

## Verification
A stale edge-detect stage appears at the ports as a missing pulse, or as a pulse that repeats while a line is held high. It is visible three cycles after the stimulus. A corrupted downscale counter moves the second-level pulse off the N-th first-level pulse, and this shows at the next expected second-level pulse. A wrong priority encoder gives a wrong `l1_type_o` in the same cycle as the pulse, whenever two sources fire together. The bench compares every cycle against a cycle-exact model, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/trig_sel_pkg.sv
package trig_sel_pkg;
  localparam int N_LVDS   = 5;
  localparam int N_TTL    = 5;
  localparam int N_SRC    = 16;
  localparam int TYPE_W   = 4;
  localparam int DS_W     = 8;
  localparam int RAW_W    = 15;
  localparam int L1_RAW_W = 13;

  // enable-bit positions (also the internal type codes)
  localparam int EN_REF    = 10;
  localparam int EN_SELF   = 11;
  localparam int EN_CO_LV  = 12;
  localparam int EN_SW     = 13;
  localparam int EN_CO_T01 = 14;
  localparam int EN_CO_T23 = 15;

  // control word fields
  localparam int SW_BIT   = 28;
  localparam int L2SEL_LO = 16;
  localparam int DS_LO    = 20;

  // raw vector layout
  localparam int RAW_TTL  = 5;
  localparam int RAW_REF  = 10;
  localparam int RAW_SELF = 11;
  localparam int RAW_SW   = 12;
  localparam int RAW_L2LV = 13;
  localparam int RAW_L2LO = 14;

  typedef enum logic [1:0] {
    L2_AUTO  = 2'b00,
    L2_LVDS  = 2'b01,
    L2_LOCAL = 2'b10,
    L2_NONE  = 2'b11
  } l2_src_e;
endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge #(
  parameter int W      = 15,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] sync_q;
  logic [W-1:0]             prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= '0;
          else        sync_q[0] <= raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= '0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign prev_o = prev_q;
  assign rise_o = lvl_o & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & $past(rise_o)) == '0); // R2
endmodule

// File: rtl/trig_l1_combiner.sv
module trig_l1_combiner
  import trig_sel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [L1_RAW_W-1:0] lvl_i,
  input  logic [L1_RAW_W-1:0] prev_i,
  input  logic [N_SRC-1:0]    en_i,
  input  logic [4:0]          type_sel_i,
  output logic                fire_o,
  output logic                l1_o,
  output logic [TYPE_W-1:0]   type_o
);
  logic [N_SRC-1:0]  act;
  logic [N_SRC-1:0]  hit;
  logic [TYPE_W-1:0] low_idx;

  genvar i;
  generate
    for (i = 0; i < N_LVDS; i++) begin : g_lvds
      assign act[i] = lvl_i[i] & ~prev_i[i];
    end
    for (i = 0; i < N_TTL; i++) begin : g_ttl
      assign act[N_LVDS+i] = lvl_i[RAW_TTL+i] & ~prev_i[RAW_TTL+i];
    end
  endgenerate

  assign act[EN_REF]    = lvl_i[RAW_REF]  & ~prev_i[RAW_REF];
  assign act[EN_SELF]   = lvl_i[RAW_SELF] & ~prev_i[RAW_SELF];
  assign act[EN_SW]     = lvl_i[RAW_SW]   & ~prev_i[RAW_SW];
  assign act[EN_CO_LV]  = (lvl_i[0] & lvl_i[1]) & ~(prev_i[0] & prev_i[1]);
  assign act[EN_CO_T01] = (lvl_i[RAW_TTL] & lvl_i[RAW_TTL+1])
                        & ~(prev_i[RAW_TTL] & prev_i[RAW_TTL+1]);
  assign act[EN_CO_T23] = (lvl_i[RAW_TTL+2] & lvl_i[RAW_TTL+3])
                        & ~(prev_i[RAW_TTL+2] & prev_i[RAW_TTL+3]);

  assign hit    = act & en_i;
  assign fire_o = |hit;

  always_comb begin
    low_idx = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (hit[k]) low_idx = TYPE_W'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_o   <= 1'b0;
      type_o <= '0;
    end else begin
      l1_o   <= fire_o;
      type_o <= !fire_o ? '0 : (type_sel_i[4] ? type_sel_i[3:0] : low_idx);
    end
  end

  AST_TYPE_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !l1_o |-> type_o == '0); // R7
  AST_FORCED_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_o && $past(type_sel_i[4])) |-> type_o == $past(type_sel_i[3:0])); // R7
endmodule

// File: rtl/trig_l2_select.sv
module trig_l2_select
  import trig_sel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel_i,
  input  logic [DS_W-1:0] ds_i,
  input  logic            l1_fire_i,
  input  logic            lvds_rise_i,
  input  logic            local_rise_i,
  output logic            l2_o
);
  l2_src_e       mode;
  logic [DS_W-1:0] cnt_q;
  logic [DS_W:0]   lim;
  logic          reach;

  assign mode  = l2_src_e'(sel_i);
  assign lim   = (ds_i == '0) ? (DS_W+1)'(1) : {1'b0, ds_i};
  assign reach = ({1'b0, cnt_q} + (DS_W+1)'(1)) >= lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      l2_o  <= 1'b0;
    end else begin
      unique case (mode)
        L2_AUTO: begin
          if (l1_fire_i) begin
            cnt_q <= reach ? '0 : cnt_q + 1'b1;
            l2_o  <= reach;
          end else begin
            l2_o <= 1'b0;
          end
        end
        L2_LVDS: begin
          cnt_q <= '0;
          l2_o  <= lvds_rise_i;
        end
        L2_LOCAL: begin
          cnt_q <= '0;
          l2_o  <= local_rise_i;
        end
        default: begin
          cnt_q <= '0;
          l2_o  <= 1'b0;
        end
      endcase
    end
  end

  AST_L2_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_i) == L2_NONE |-> !l2_o); // R9
  AST_AUTO_NEEDS_L1: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_o && $past(sel_i) == L2_AUTO) |-> $past(l1_fire_i)); // R8
endmodule

// File: rtl/trig_src_sel.sv
module trig_src_sel
  import trig_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LVDS-1:0] lvds_trig_i,
  input  logic [N_TTL-1:0]  ttl_trig_i,
  input  logic              ref_trig_i,
  input  logic              self_trig_i,
  input  logic [31:0]       ctrl_i,
  input  logic [4:0]        type_sel_i,
  input  logic              l2_lvds_i,
  input  logic              l2_local_i,
  output logic              l1_trig_o,
  output logic [TYPE_W-1:0] l1_type_o,
  output logic              l2_trig_o
);
  logic [RAW_W-1:0] raw, lvl, prev, rise;
  logic             l1_fire;
  logic             unused_bits;

  assign raw = {l2_local_i, l2_lvds_i, ctrl_i[SW_BIT], self_trig_i,
                ref_trig_i, ttl_trig_i, lvds_trig_i};

  trig_sync_edge #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_i (raw),
    .lvl_o (lvl),
    .prev_o(prev),
    .rise_o(rise)
  );

  trig_l1_combiner u_l1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl_i     (lvl[L1_RAW_W-1:0]),
    .prev_i    (prev[L1_RAW_W-1:0]),
    .en_i      (ctrl_i[N_SRC-1:0]),
    .type_sel_i(type_sel_i),
    .fire_o    (l1_fire),
    .l1_o      (l1_trig_o),
    .type_o    (l1_type_o)
  );

  trig_l2_select u_l2 (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (ctrl_i[L2SEL_LO+1:L2SEL_LO]),
    .ds_i        (ctrl_i[DS_LO+DS_W-1:DS_LO]),
    .l1_fire_i   (l1_fire),
    .lvds_rise_i (rise[RAW_L2LV]),
    .local_rise_i(rise[RAW_L2LO]),
    .l2_o        (l2_trig_o)
  );

  assign unused_bits = ^{ctrl_i[31:29], ctrl_i[19:18], rise[L1_RAW_W-1:0],
                         lvl[RAW_W-1:L1_RAW_W], prev[RAW_W-1:L1_RAW_W]};

  AST_L2_AUTO_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_trig_o && $past(ctrl_i[17:16]) == 2'b00) |-> l1_trig_o); // R8
endmodule

// File: tb/trig_src_sel_tb_top.sv
module trig_src_sel_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [4:0]  lvds, ttl;
  logic        ref_t, self_t, l2lv, l2lo;
  logic [31:0] ctrl;
  logic [4:0]  tsel;
  logic        l1;
  logic [3:0]  l1_type;
  logic        l2;

  trig_src_sel dut_i (
    .clk(clk), .rst_n(rst_n), .lvds_trig_i(lvds), .ttl_trig_i(ttl),
    .ref_trig_i(ref_t), .self_trig_i(self_t), .ctrl_i(ctrl),
    .type_sel_i(tsel), .l2_lvds_i(l2lv), .l2_local_i(l2lo),
    .l1_trig_o(l1), .l1_type_o(l1_type), .l2_trig_o(l2)
  );

  int checks = 0;
  int fails  = 0;
  logic [14:0] hist [4];
  logic [31:0] ctrl_h;
  logic [4:0]  ts_h;
  int          ds_cnt;

  // raw layout: [4:0] lvds, [9:5] ttl, 10 ref, 11 self, 12 sw, 13 l2 lvds, 14 l2 local
  function automatic logic [15:0] src_act(logic [14:0] c, logic [14:0] p);
    logic [15:0] a;
    logic [14:0] r;
    r = c & ~p;
    a[9:0] = r[9:0];
    a[10]  = r[10];
    a[11]  = r[11];
    a[13]  = r[12];
    a[12]  = (c[0] & c[1]) & ~(p[0] & p[1]);
    a[14]  = (c[5] & c[6]) & ~(p[5] & p[6]);
    a[15]  = (c[7] & c[8]) & ~(p[7] & p[8]);
    return a;
  endfunction

  function automatic logic [3:0] low_bit(logic [15:0] h);
    for (int k = 15; k >= 0; k--) if (h[k]) low_bit = 4'(k);
    if (h == '0) low_bit = 4'd0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic [14:0] v, logic [31:0] c, logic [4:0] ts, string tag);
    logic [15:0] hit;
    logic        e_l1, e_l2;
    logic [3:0]  e_ty;
    int          lim;
    @(negedge clk);
    hit  = src_act(hist[2], hist[3]) & ctrl_h[15:0];
    e_l1 = |hit;
    e_ty = !e_l1 ? 4'd0 : (ts_h[4] ? ts_h[3:0] : low_bit(hit));
    e_l2 = 1'b0;
    case (ctrl_h[17:16])
      2'b00: if (e_l1) begin
        lim = (ctrl_h[27:20] == 0) ? 1 : int'(ctrl_h[27:20]);
        if (ds_cnt + 1 >= lim) begin e_l2 = 1'b1; ds_cnt = 0; end
        else ds_cnt++;
      end
      2'b01: begin e_l2 = hist[2][13] & ~hist[3][13]; ds_cnt = 0; end
      2'b10: begin e_l2 = hist[2][14] & ~hist[3][14]; ds_cnt = 0; end
      default: ds_cnt = 0;
    endcase
    chk(tag, int'(l1), int'(e_l1));
    chk(ts_h[4] ? "R7" : "R6", int'(l1_type), int'(e_ty));
    chk(ctrl_h[17:16] == 2'b00 ? "R8" : "R9", int'(l2), int'(e_l2));
    lvds = v[4:0]; ttl = v[9:5]; ref_t = v[10]; self_t = v[11];
    l2lv = v[13];  l2lo = v[14];
    ctrl = c; ctrl[28] = v[12];
    tsel = ts;
    hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = v;
    ctrl_h = ctrl; ts_h = ts;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [14:0] v;
    logic [31:0] c;
    logic [4:0]  ts;
    void'($urandom(32'd7301));
    rst_n = 1'b0;
    lvds = '0; ttl = '0; ref_t = 0; self_t = 0; l2lv = 0; l2lo = 0;
    ctrl = '0; tsel = '0;
    for (int i = 0; i < 4; i++) hist[i] = '0;
    ctrl_h = '0; ts_h = '0; ds_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'(l1), 0);
    chk("R1", int'(l1_type), 0);
    chk("R1", int'(l2), 0);
    rst_n = 1'b1;

    // R2: only LVDS line 2 enabled; line 1 and falling edges ignored
    c = 32'h0030_0004; ts = 5'd0; v = '0;
    v[1] = 1; step(v, c, ts, "R2");
    v[1] = 0; step(v, c, ts, "R2");
    v[2] = 1; step(v, c, ts, "R2");
    for (int i = 0; i < 4; i++) step(v, c, ts, "R2");
    v[2] = 0; for (int i = 0; i < 5; i++) step(v, c, ts, "R2");

    // R3: reference and self-trigger lines
    c = 32'h0003_0C00;
    v[10] = 1; step(v, c, ts, "R3");
    v[11] = 1; step(v, c, ts, "R3");
    v[10] = 0; v[11] = 0; for (int i = 0; i < 5; i++) step(v, c, ts, "R3");

    // R4: software bit held high fires only once
    c = 32'h0003_2000;
    v[12] = 1; for (int i = 0; i < 10; i++) step(v, c, ts, "R4");
    v[12] = 0; for (int i = 0; i < 4; i++) step(v, c, ts, "R4");
    v[12] = 1; for (int i = 0; i < 5; i++) step(v, c, ts, "R4");
    v[12] = 0; for (int i = 0; i < 4; i++) step(v, c, ts, "R4");

    // R5: coincidences of fixed pairs
    c = 32'h0003_D000;
    v[0] = 1; step(v, c, ts, "R5");
    step(v, c, ts, "R5");
    v[1] = 1; step(v, c, ts, "R5");
    v[5] = 1; v[6] = 1; step(v, c, ts, "R5");
    v[7] = 1; step(v, c, ts, "R5");
    v[8] = 1; step(v, c, ts, "R5");
    v[0] = 0; v[1] = 0; v[5] = 0; v[6] = 0; v[7] = 0; v[8] = 0;
    for (int i = 0; i < 5; i++) step(v, c, ts, "R5");

    // R7: forced type
    c = 32'h0003_03FF; ts = 5'h1A;
    v[3] = 1; v[6] = 1; step(v, c, ts, "R7");
    v[3] = 0; v[6] = 0; for (int i = 0; i < 5; i++) step(v, c, ts, "R7");
    ts = 5'd0;

    // R8: downscale of 0 acts as 1, then N = 3
    c = 32'h0000_03FF;
    for (int i = 0; i < 6; i++) begin
      v[i % 5] = ~v[i % 5]; step(v, c, ts, "R8"); step(v, c, ts, "R8");
    end
    c = 32'h0030_03FF;
    for (int i = 0; i < 14; i++) begin
      v[i % 10] = ~v[i % 10]; step(v, c, ts, "R8"); step(v, c, ts, "R8");
    end

    // R9: external, local and disabled second-level modes
    for (int m = 1; m < 4; m++) begin
      c = 32'h0000_03FF | (32'(m) << 16);
      for (int i = 0; i < 40; i++) begin
        v = v ^ (15'($urandom) & 15'($urandom));
        step(v, c, ts, "R9");
      end
    end

    // random phases: R2 R3 R5 R6 R8
    for (int p = 0; p < 12; p++) begin
      c = $urandom;
      c[27:20] = 8'($urandom % 5);
      ts = 5'($urandom);
      for (int i = 0; i < 400; i++) begin
        v = v ^ (15'($urandom) & 15'($urandom) & 15'($urandom));
        step(v, c, ts, "R2");
      end
    end
    v = '0;
    for (int i = 0; i < 6; i++) step(v, c, ts, "R2");

    summary();
    $finish;
  end
endmodule